// File: doc/BRIEF.md
# L1 Data Cache Maintenance Engine

This block holds the state of a small direct-mapped write-back data cache (valid, dirty, tag and one data word per line) and runs maintenance commands on it. Software writes a command through a narrow register port. The command can clean (write back dirty lines), discard, or clean and then discard, either for the whole cache or for the single line that holds a given physical address. The engine then walks the affected lines, one per clock. For each dirty line that must be saved it raises a request on a write-back port and waits for the memory side to acknowledge.

A control register holds a disable bit, an invalidate-behaviour bit and a read-only busy bit. Software starts a command and polls the busy bit until it reads zero. A fill port lets the surrounding logic install lines, and a probe port reports the state of the line that an address maps to. A command issued while the engine is busy is parked in one slot and runs when the engine is free.

Top module: `l1d_maint`

## Requirements
- R1: After reset the control readback is all zero, no write-back is requested, and every probe misses.
- R2: The register select codes are 0 for control, 1 for whole-cache invalidate, 2 for whole-cache flush, 3 for line invalidate and 4 for line flush. In the control readback, bit 0 is disable, bit 6 is invalidate mode and bit 8 is busy. Every other bit reads zero. The data written with a whole-cache command has no effect.
- R3: With invalidate mode 0, an invalidate drops each selected line without any write-back.
- R4: With invalidate mode 1, an invalidate first writes back each selected line that is valid and dirty, and then drops it.
- R5: A flush writes back each selected line that is valid and dirty, then marks it clean and leaves it valid. Clean lines and invalid lines cause no write-back.
- R6: A whole-cache command visits the lines in ascending index order, one per cycle. When nothing needs writing back, busy reads 1 for exactly NUM_LINES+1 cycles after the command write.
- R7: A line command selects the line by the index bits of its address and ignores the offset bits. It acts only when that line is valid and its tag equals the tag bits of the address. Otherwise nothing changes, and busy lasts 2 cycles.
- R8: Busy is 1 from the cycle after a command is accepted until the last write-back of that command has been acknowledged and the walk has ended. No write-back is requested while busy is 0.
- R9: A write-back request holds the line base address (offset bits zero) and the line data steady until it is acknowledged.
- R10: While the disable bit is 1, command writes are ignored: busy stays 0 and the lines are unchanged.
- R11: A command written while busy is held and runs after the current command finishes. Its effect is applied to the cache state that the first command left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | ADDR_W | Write data: control bits or line address |
| ctrl_rdata | output | 9 | Control readback: busy, invalidate mode, disable |
| fill_en | input | 1 | Install a line (taken only while not busy) |
| fill_addr | input | ADDR_W | Address of the installed line |
| fill_data | input | DATA_W | Data of the installed line |
| fill_dirty | input | 1 | Installed line is dirty |
| probe_addr | input | ADDR_W | Address to look up |
| probe_hit | output | 1 | Line is valid with matching tag |
| probe_dirty | output | 1 | Probed line is dirty |
| probe_data | output | DATA_W | Probed line data |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | ADDR_W | Write-back line base address |
| wb_data | output | DATA_W | Write-back data |
| wb_ack | input | 1 | Write-back accepted |

## Verification
The whole-cache commands run on caches that mix clean, dirty and invalid lines. This shows whether only valid dirty lines reach the write-back port and whether they arrive in index order. The same fill is run under flush, under invalidate in mode 0 and under invalidate in mode 1, which separates the three line outcomes (kept clean, dropped, saved then dropped). Line commands use addresses with non-zero offset bits and with a mismatching tag, which shows that offset bits are ignored and tags are compared. A held second command, issued during a slow-acknowledge flush, checks the queueing order. A command sent while disabled checks that the disable bit is obeyed.

// File: rtl/l1d_maint_pkg.sv
// Shared types and register codes for the cache maintenance engine.
package l1d_maint_pkg;

    // Maintenance operation carried from the register port to the walker.
    typedef enum logic [1:0] {
        MOP_NONE  = 2'd0,
        MOP_INV   = 2'd1,
        MOP_FLUSH = 2'd2
    } mop_e;

    // Walker state.
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_SCAN = 2'd1,
        WS_WB   = 2'd2
    } wstate_e;

    // Register select codes.
    localparam logic [2:0] SEL_CTRL       = 3'd0;
    localparam logic [2:0] SEL_ALL_INV    = 3'd1;
    localparam logic [2:0] SEL_ALL_FLUSH  = 3'd2;
    localparam logic [2:0] SEL_LINE_INV   = 3'd3;
    localparam logic [2:0] SEL_LINE_FLUSH = 3'd4;

    // Control register bit positions.
    localparam int CTRL_DIS_BIT  = 0;
    localparam int CTRL_MODE_BIT = 6;
    localparam int CTRL_BUSY_BIT = 8;

endpackage

// File: rtl/l1d_maint_regs.sv
// Control register and single-slot command holder.
// Assumes: take is raised only while pend_v is set; a new command write
// in the same cycle as take replaces the consumed one.
module l1d_maint_regs
    import l1d_maint_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              take,
    output logic              dis_q,
    output logic              mode_q,
    output logic              pend_v,
    output mop_e              pend_op,
    output logic              pend_whole,
    output logic [ADDR_W-1:0] pend_addr
);

    logic is_cmd;
    mop_e dec_op;
    logic dec_whole;

    // Decode the register select into an operation and its scope.
    always_comb begin
        is_cmd    = 1'b1;
        dec_op    = MOP_NONE;
        dec_whole = 1'b0;
        case (cfg_sel)
            SEL_ALL_INV:    begin dec_op = MOP_INV;   dec_whole = 1'b1; end
            SEL_ALL_FLUSH:  begin dec_op = MOP_FLUSH; dec_whole = 1'b1; end
            SEL_LINE_INV:   dec_op = MOP_INV;
            SEL_LINE_FLUSH: dec_op = MOP_FLUSH;
            default:        is_cmd = 1'b0;
        endcase
    end

    // Control register bits written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q  <= 1'b0;
            mode_q <= 1'b0;
        end else if (cfg_we && cfg_sel == SEL_CTRL) begin
            dis_q  <= cfg_wdata[CTRL_DIS_BIT];
            mode_q <= cfg_wdata[CTRL_MODE_BIT];
        end
    end

    // Command slot: filled by an enabled command write, emptied by the walker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v     <= 1'b0;
            pend_op    <= MOP_NONE;
            pend_whole <= 1'b0;
            pend_addr  <= '0;
        end else begin
            if (take)
                pend_v <= 1'b0;
            if (cfg_we && is_cmd && !dis_q) begin
                pend_v     <= 1'b1;
                pend_op    <= dec_op;
                pend_whole <= dec_whole;
                pend_addr  <= cfg_wdata;
            end
        end
    end

endmodule

// File: rtl/l1d_maint_lines.sv
// Line state storage: valid, dirty, tag and one data word per line.
// Assumes: fill_en is already gated off while the walker is busy, so
// walker updates and fills never collide.
module l1d_maint_lines #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3,
    parameter int TAG_W     = 9,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_dirty,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic              clr_valid,
    input  logic              clr_dirty,
    input  logic [IDX_W-1:0]  probe_idx,
    input  logic [TAG_W-1:0]  probe_tag,
    output logic              cur_v,
    output logic              cur_d,
    output logic [TAG_W-1:0]  cur_tag,
    output logic [DATA_W-1:0] cur_data,
    output logic              probe_hit,
    output logic              probe_dirty,
    output logic [DATA_W-1:0] probe_data
);

    logic [NUM_LINES-1:0] v_q;
    logic [NUM_LINES-1:0] d_q;
    logic [TAG_W-1:0]     tag_q  [NUM_LINES];
    logic [DATA_W-1:0]    data_q [NUM_LINES];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic sel_cur;
        logic sel_fill;
        assign sel_cur  = (cur_idx == IDX_W'(i));
        assign sel_fill = fill_en && (fill_idx == IDX_W'(i));

        // Per-line state: fill installs, walker clears valid or dirty.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[i]    <= 1'b0;
                d_q[i]    <= 1'b0;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end else if (sel_fill) begin
                v_q[i]    <= 1'b1;
                d_q[i]    <= fill_dirty;
                tag_q[i]  <= fill_tag;
                data_q[i] <= fill_data;
            end else if (sel_cur && clr_valid) begin
                v_q[i] <= 1'b0;
                d_q[i] <= 1'b0;
            end else if (sel_cur && clr_dirty) begin
                d_q[i] <= 1'b0;
            end
        end
    end

    // Read the line the walker is visiting.
    always_comb begin
        cur_v    = v_q[cur_idx];
        cur_d    = d_q[cur_idx];
        cur_tag  = tag_q[cur_idx];
        cur_data = data_q[cur_idx];
    end

    // Look up the probe address.
    always_comb begin
        probe_hit   = v_q[probe_idx] && (tag_q[probe_idx] == probe_tag);
        probe_dirty = probe_hit && d_q[probe_idx];
        probe_data  = data_q[probe_idx];
    end

endmodule

// File: rtl/l1d_maint_walk.sv
// Walker: visits one line per cycle, writes back where required and
// clears valid or dirty state. A whole-cache walk covers every index in
// ascending order; a line walk covers one index with a tag compare.
// Assumes: the visited line does not change while a write-back waits.
module l1d_maint_walk
    import l1d_maint_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 3,
    parameter int TAG_W     = 9,
    parameter int OFF_W     = 4,
    parameter int DATA_W    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pend_v,
    input  mop_e                         pend_op,
    input  logic                         pend_whole,
    input  logic [IDX_W-1:0]             pend_idx,
    input  logic [TAG_W-1:0]             pend_tag,
    input  logic                         mode_q,
    input  logic                         line_v,
    input  logic                         line_d,
    input  logic [TAG_W-1:0]             line_tag,
    input  logic [DATA_W-1:0]            line_data,
    input  logic                         wb_ack,
    output logic                         take,
    output logic [IDX_W-1:0]             cur_idx,
    output logic                         active,
    output logic                         clr_valid,
    output logic                         clr_dirty,
    output logic                         wb_req,
    output logic [TAG_W+IDX_W+OFF_W-1:0] wb_addr,
    output logic [DATA_W-1:0]            wb_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    wstate_e          st_q;
    logic [IDX_W-1:0] idx_q;
    logic [TAG_W-1:0] tag_q;
    logic             whole_q;
    logic             do_wb_q;
    logic             do_inv_q;

    logic match;
    logic need_wb;
    logic step;
    logic last;

    // Per-line decision for the visited index.
    always_comb begin
        match     = line_v && (whole_q || line_tag == tag_q);
        need_wb   = do_wb_q && match && line_d;
        last      = !whole_q || idx_q == LAST_IDX;
        take      = (st_q == WS_IDLE) && pend_v;
        wb_req    = (st_q == WS_WB);
        step      = 1'b0;
        clr_valid = 1'b0;
        clr_dirty = 1'b0;
        if (st_q == WS_SCAN && !need_wb) begin
            step      = 1'b1;
            clr_valid = do_inv_q && match;
        end else if (st_q == WS_WB && wb_ack) begin
            step      = 1'b1;
            clr_valid = do_inv_q;
            clr_dirty = !do_inv_q;
        end
    end

    // Walk sequencing: load a held command, advance, wait on write-backs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= WS_IDLE;
            idx_q    <= '0;
            tag_q    <= '0;
            whole_q  <= 1'b0;
            do_wb_q  <= 1'b0;
            do_inv_q <= 1'b0;
        end else begin
            case (st_q)
                WS_IDLE: if (pend_v) begin
                    st_q     <= WS_SCAN;
                    idx_q    <= pend_whole ? '0 : pend_idx;
                    tag_q    <= pend_tag;
                    whole_q  <= pend_whole;
                    do_inv_q <= (pend_op == MOP_INV);
                    do_wb_q  <= (pend_op == MOP_FLUSH) ||
                                (pend_op == MOP_INV && mode_q);
                end
                WS_SCAN: if (need_wb) st_q <= WS_WB;
                default: ;
            endcase
            if (step) begin
                if (last) begin
                    st_q <= WS_IDLE;
                end else begin
                    st_q  <= WS_SCAN;
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign cur_idx = idx_q;
    assign active  = (st_q != WS_IDLE);
    assign wb_addr = {line_tag, idx_q, {OFF_W{1'b0}}};
    assign wb_data = line_data;

endmodule

// File: rtl/l1d_maint.sv
// Top of the data cache maintenance engine: register port, held command,
// line storage and walker. Line size is 2**OFF_W bytes, one data word
// modelled per line; NUM_LINES must be a power of two.
module l1d_maint
    import l1d_maint_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int NUM_LINES  = 8,
    parameter int LINE_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [8:0]        ctrl_rdata,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_dirty,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic              probe_dirty,
    output logic [DATA_W-1:0] probe_data,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              wb_ack
);

    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    logic              dis_q, mode_q, pend_v, pend_whole, take, active, busy;
    mop_e              pend_op;
    logic [ADDR_W-1:0] pend_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic              clr_valid, clr_dirty;
    logic              line_v, line_d;
    logic [TAG_W-1:0]  line_tag;
    logic [DATA_W-1:0] line_data;
    logic              unused_off;

    assign unused_off = ^{fill_addr[OFF_W-1:0], probe_addr[OFF_W-1:0],
                          pend_addr[OFF_W-1:0]};

    assign busy = active || pend_v;

    // Control readback: busy, invalidate mode, disable; rest zero.
    always_comb begin
        ctrl_rdata                = '0;
        ctrl_rdata[CTRL_DIS_BIT]  = dis_q;
        ctrl_rdata[CTRL_MODE_BIT] = mode_q;
        ctrl_rdata[CTRL_BUSY_BIT] = busy;
    end

    l1d_maint_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .take(take), .dis_q(dis_q), .mode_q(mode_q),
        .pend_v(pend_v), .pend_op(pend_op), .pend_whole(pend_whole),
        .pend_addr(pend_addr)
    );

    l1d_maint_lines #(
        .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) lines_i (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en && !busy),
        .fill_idx(fill_addr[OFF_W +: IDX_W]),
        .fill_tag(fill_addr[ADDR_W-1 -: TAG_W]),
        .fill_data(fill_data), .fill_dirty(fill_dirty),
        .cur_idx(cur_idx), .clr_valid(clr_valid), .clr_dirty(clr_dirty),
        .probe_idx(probe_addr[OFF_W +: IDX_W]),
        .probe_tag(probe_addr[ADDR_W-1 -: TAG_W]),
        .cur_v(line_v), .cur_d(line_d), .cur_tag(line_tag),
        .cur_data(line_data), .probe_hit(probe_hit),
        .probe_dirty(probe_dirty), .probe_data(probe_data)
    );

    l1d_maint_walk #(
        .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W),
        .OFF_W(OFF_W), .DATA_W(DATA_W)
    ) walk_i (
        .clk(clk), .rst_n(rst_n), .pend_v(pend_v), .pend_op(pend_op),
        .pend_whole(pend_whole),
        .pend_idx(pend_addr[OFF_W +: IDX_W]),
        .pend_tag(pend_addr[ADDR_W-1 -: TAG_W]),
        .mode_q(mode_q), .line_v(line_v), .line_d(line_d),
        .line_tag(line_tag), .line_data(line_data), .wb_ack(wb_ack),
        .take(take), .cur_idx(cur_idx), .active(active),
        .clr_valid(clr_valid), .clr_dirty(clr_dirty), .wb_req(wb_req),
        .wb_addr(wb_addr), .wb_data(wb_data)
    );

endmodule

// File: rtl/l1d_maint_chk.sv
// Protocol checker for the maintenance engine, bound to its top.
module l1d_maint_chk #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [2:0]        cfg_sel,
    input logic [8:0]        ctrl_rdata,
    input logic              wb_req,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [DATA_W-1:0] wb_data,
    input logic              wb_ack
);

    localparam int OFF_W = $clog2(LINE_BYTES);

    logic busy;
    assign busy = ctrl_rdata[8];

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr) && $stable(wb_data))); // R9

    AST_WB_LINE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (wb_addr[OFF_W-1:0] == '0)); // R9

    AST_WB_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> busy); // R8

    AST_DISABLED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel >= 3'd1 && cfg_sel <= 3'd4 && ctrl_rdata[0] && !busy)
        |=> !busy); // R10

    AST_CMD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel >= 3'd1 && cfg_sel <= 3'd4 && !ctrl_rdata[0])
        |=> busy); // R8

    AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[5:1] == '0) && !ctrl_rdata[7]); // R2

endmodule

bind l1d_maint l1d_maint_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .ctrl_rdata(ctrl_rdata), .wb_req(wb_req), .wb_addr(wb_addr),
    .wb_data(wb_data), .wb_ack(wb_ack)
);

// File: tb/l1d_maint_tb_top.sv
// Bench: behavioural model of the line state and of the expected
// write-back stream, compared against the ports.
module l1d_maint_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [8:0]  ctrl_rdata;
    logic        fill_en = 1'b0;
    logic [15:0] fill_addr = 16'd0;
    logic [31:0] fill_data = 32'd0;
    logic        fill_dirty = 1'b0;
    logic [15:0] probe_addr = 16'd0;
    logic        probe_hit, probe_dirty;
    logic [31:0] probe_data;
    logic        wb_req;
    logic [15:0] wb_addr;
    logic [31:0] wb_data;
    logic        wb_ack = 1'b0;

    int total = 0;
    int bad = 0;
    int ack_delay = 0;
    int ack_cnt = 0;

    bit          m_v [8];
    bit          m_d [8];
    logic [8:0]  m_t [8];
    logic [31:0] m_dat [8];
    logic [15:0] f_addr [8];
    bit          m_dis = 0;
    bit          m_mode = 0;
    logic [47:0] exp_q [$];
    logic [47:0] obs_q [$];

    always #5 clk = ~clk;

    l1d_maint dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ctrl_rdata(ctrl_rdata), .fill_en(fill_en),
        .fill_addr(fill_addr), .fill_data(fill_data), .fill_dirty(fill_dirty),
        .probe_addr(probe_addr), .probe_hit(probe_hit),
        .probe_dirty(probe_dirty), .probe_data(probe_data),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_data(wb_data),
        .wb_ack(wb_ack)
    );

    // Memory side: acknowledge after ack_delay cycles, record each write-back.
    always @(negedge clk) begin
        if (wb_ack) begin
            wb_ack = 1'b0;
        end else if (wb_req) begin
            if (ack_cnt >= ack_delay) begin
                wb_ack = 1'b1;
                obs_q.push_back({wb_addr, wb_data});
                ack_cnt = 0;
            end else begin
                ack_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input logic [15:0] a, input logic [31:0] d, input bit dirty);
        @(negedge clk);
        fill_en = 1'b1; fill_addr = a; fill_data = d; fill_dirty = dirty;
        @(negedge clk);
        fill_en = 1'b0;
        m_v[a[6:4]] = 1; m_d[a[6:4]] = dirty; m_t[a[6:4]] = a[15:7];
        m_dat[a[6:4]] = d; f_addr[a[6:4]] = a;
    endtask

    // Model of one command: expected write-backs and line state changes.
    task automatic model_cmd(input logic [2:0] sel, input logic [15:0] a);
        bit whole, inv, match, wb;
        int lo, hi;
        whole = (sel == 3'd1 || sel == 3'd2);
        inv   = (sel == 3'd1 || sel == 3'd3);
        lo = whole ? 0 : int'(a[6:4]);
        hi = whole ? 7 : int'(a[6:4]);
        for (int i = lo; i <= hi; i++) begin
            match = m_v[i] && (whole || m_t[i] == a[15:7]);
            if (match) begin
                wb = (!inv || m_mode) && m_d[i];
                if (wb) exp_q.push_back({m_t[i], 3'(i), 4'b0, m_dat[i]});
                if (inv) begin m_v[i] = 0; m_d[i] = 0; end
                else if (wb) m_d[i] = 0;
            end
        end
    endtask

    task automatic do_cmd(input logic [2:0] sel, input logic [15:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 3'd0) begin
            m_dis = val[0]; m_mode = val[6];
        end else if (!m_dis) begin
            model_cmd(sel, val);
        end
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (ctrl_rdata[8] && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic compare_wb(input string req);
        logic [47:0] o, e;
        check(obs_q.size() == exp_q.size(), req, 64'(obs_q.size()), 64'(exp_q.size()));
        while (obs_q.size() > 0 && exp_q.size() > 0) begin
            o = obs_q.pop_front();
            e = exp_q.pop_front();
            check(o == e, req, 64'(o), 64'(e));
            check(o[35:32] == 4'd0, "R9 line base", 64'(o[35:32]), 64'd0);
        end
        obs_q.delete();
        exp_q.delete();
    endtask

    task automatic compare_lines(input string req);
        for (int i = 0; i < 8; i++) begin
            probe_addr = f_addr[i];
            #1;
            check(probe_hit == m_v[i], req, 64'(probe_hit), 64'(m_v[i]));
            if (m_v[i]) begin
                check(probe_dirty == m_d[i], req, 64'(probe_dirty), 64'(m_d[i]));
                check(probe_data == m_dat[i], req, 64'(probe_data), 64'(m_dat[i]));
            end
        end
    endtask

    task automatic fill_all(input logic [8:0] tg, input logic [7:0] dmask);
        for (int i = 0; i < 8; i++)
            fill({tg, 3'(i), 4'h0}, 32'hA000_0000 + 32'(tg) * 256 + 32'(i), dmask[i]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < 8; i++) f_addr[i] = 16'(i * 16);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        check(ctrl_rdata == 9'h000, "R1 ctrl", 64'(ctrl_rdata), 64'h0);
        check(wb_req == 1'b0, "R1 wb_req", 64'(wb_req), 64'h0);
        compare_lines("R1 lines");

        // R5 R6: whole flush over mixed dirty lines, acks after one cycle.
        ack_delay = 1;
        fill_all(9'h011, 8'b1010_0110);
        do_cmd(3'd2, 16'hFFFF);            // R2: data ignored for whole ops
        wait_idle(n);
        compare_wb("R5 flush write-backs in index order");
        compare_lines("R5 flush leaves lines valid clean");

        // R3 R6: invalidate mode 0 drops lines, no write-back, NUM_LINES+1 busy.
        fill_all(9'h022, 8'b0101_1001);
        do_cmd(3'd1, 16'h0000);
        wait_idle(n);
        check(n == 9, "R6 whole walk length", 64'(n), 64'd9);
        compare_wb("R3 no write-back in discard mode");
        compare_lines("R3 lines dropped");

        // R4 R2: invalidate mode 1 saves dirty lines then drops them.
        fill_all(9'h033, 8'b1100_0011);
        do_cmd(3'd0, 16'h0040);
        check(ctrl_rdata == 9'h040, "R2 ctrl readback", 64'(ctrl_rdata), 64'h40);
        ack_delay = 0;
        do_cmd(3'd1, 16'h1234);
        wait_idle(n);
        compare_wb("R4 save then drop");
        compare_lines("R4 lines dropped");

        // R7: line commands with offset bits set and tag mismatch.
        fill_all(9'h044, 8'b1111_0000);
        do_cmd(3'd4, {9'h044, 3'd5, 4'hB});
        wait_idle(n);
        compare_wb("R7 line flush");
        compare_lines("R7 line flush state");
        do_cmd(3'd3, {9'h055, 3'd6, 4'h3});
        wait_idle(n);
        check(n == 2, "R7 mismatch walk length", 64'(n), 64'd2);
        compare_wb("R7 mismatch no write-back");
        compare_lines("R7 mismatch unchanged");
        do_cmd(3'd0, 16'h0000);
        do_cmd(3'd3, {9'h044, 3'd7, 4'hF});
        wait_idle(n);
        compare_wb("R7 line discard");
        compare_lines("R7 line discard state");

        // R10: disabled engine ignores commands.
        do_cmd(3'd0, 16'h0001);
        check(ctrl_rdata == 9'h001, "R10 ctrl readback", 64'(ctrl_rdata), 64'h1);
        do_cmd(3'd1, 16'h0000);
        check(ctrl_rdata[8] == 1'b0, "R10 busy stays low", 64'(ctrl_rdata[8]), 64'h0);
        compare_wb("R10 no write-back");
        compare_lines("R10 lines unchanged");
        do_cmd(3'd0, 16'h0000);

        // R11 R8: second command held behind a slow flush.
        fill_all(9'h066, 8'b1111_1111);
        ack_delay = 3;
        do_cmd(3'd2, 16'h0000);
        check(ctrl_rdata[8] == 1'b1, "R8 busy during flush", 64'(ctrl_rdata[8]), 64'h1);
        do_cmd(3'd3, {9'h066, 3'd2, 4'h0});
        wait_idle(n);
        check(obs_q.size() == 8, "R8 all acks before idle", 64'(obs_q.size()), 64'd8);
        compare_wb("R11 held command order");
        compare_lines("R11 held command effect");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule